// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs the management side of a two-wire PHY management bus. A host on the same clock issues a one-cycle request carrying an opcode, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then generates the management clock `mdc` by dividing the host clock, and shifts out one complete Clause 22 frame. For a read, it also collects the 16 bits that the PHY returns. The bidirectional data pin is split into an input, an output and an active-high release (tristate) control, so a pad buffer can be placed outside the block.

The `mdc` rate is set by a 5-bit divide value and gated by an enable input. While the block is busy, `ready` is low. A request that arrives when `ready` is low, when the enable is off, or when the divide value is zero is dropped without any effect. Dropping the enable during a frame abandons that frame.

Top module: `mdio_master`

## Requirements
- R1: While reset is held and after it is released, `ready` = 1, `mdc` = 0, `mdio_o` = 1, `mdio_t` = 1 and `rd_data` = 0.
- R2: With `mdio_en` = 1 and `clk_div` = D (D ≠ 0), `mdc` toggles after every D+1 host clocks, so its period is 2·(D+1) clocks. With `mdio_en` = 0 or D = 0, `mdc` is 0 from the next clock on.
- R3: A request (`req` = 1) seen while `ready` = 1, `mdio_en` = 1 and D ≠ 0 is accepted, and `ready` is 0 on the following clock. A request seen with `mdio_en` = 0 or D = 0 is dropped and `ready` stays 1.
- R4: A request seen while `ready` = 0 is ignored. The running frame finishes unchanged and no second frame follows it.
- R5: A frame is 64 bit times, sent MSB first. Its fields are: 32 ones, start bits 01, the 2-bit opcode, `phy_addr`, `reg_addr`, two turnaround bits, then 16 data bits. For any opcode other than 2'b10, the frame is a write: the turnaround is 10, the data is `wr_data`, and the master drives all 64 bits.
- R6: `mdio_o` and `mdio_t` change only on host clock edges at which `mdc` falls, except when an abort releases the line.
- R7: Opcode 2'b10 is a read. `mdio_t` goes to 1 for the last 18 bit times, during which `mdio_o` = 1. `mdio_i` is sampled MSB first on the 16 rising `mdc` edges of the data bits. `rd_data` takes the sampled word when the frame ends, and a write leaves `rd_data` unchanged.
- R8: `ready` returns to 1, and `mdio_t` to 1, on the first falling `mdc` edge after the 64th bit time. The master drives the line (`mdio_t` = 0) only while `ready` = 0.
- R9: Taking `mdio_en` low during a frame ends it: on the next clock `ready` = 1, `mdio_t` = 1 and `mdio_o` = 1, and `rd_data` keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mdio_en | input | 1 | Enables the management clock and request service |
| clk_div | input | 5 | Divide value D; the mdc period is 2·(D+1) clocks, and 0 holds the bus off |
| req | input | 1 | One-cycle request pulse |
| op | input | 2 | Frame opcode (01 write, 10 read) |
| phy_addr | input | 5 | PHY address field |
| reg_addr | input | 5 | Register address field |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Word returned by the last completed read |
| ready | output | 1 | High when idle and able to accept a request |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value driven toward the pad |
| mdio_t | output | 1 | 1 = line released, 0 = master drives mdio_o |

## Verification
A divider counter that runs off its count shows up on `mdc` within D+1 clocks. A frame shift register or bit counter that is off by one bit puts a wrong value on `mdio_o`, or moves the release of `mdio_t` by one bit, within one `mdc` period of the fault. It also makes `ready` return early or late by a whole bit time. A sequencer that takes a request while busy or disabled pulls `ready` low, or starts a new run of preamble, on the very next clock.

// File: rtl/mdio_pkg.sv
// Shared constants for the MDIO master: sequencer states and fixed frame fields.
// Assumes Clause 22 framing only.
package mdio_pkg;
    localparam int OP_W = 2;
    localparam logic [OP_W-1:0] OP_READ  = 2'b10;
    localparam logic [1:0]      START_SEQ = 2'b01;
    localparam logic [1:0]      TA_WRITE  = 2'b10;
    localparam logic [1:0]      TA_READ   = 2'b11;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } mdio_state_t;
endpackage

// File: rtl/mdio_clkgen.sv
// Management clock divider: mdc toggles every (div+1) host clocks while run is high.
// Emits one-cycle strobes on the clock edge at which mdc rises or falls.
// Assumes run already folds in the enable bit and a non-zero divide value.
module mdio_clkgen #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             at_top;

    // a half period ends once the count reaches the divide value
    assign at_top   = (cnt_q >= div);
    assign rise_stb = run && at_top && !mdc_q;
    assign fall_stb = run && at_top && mdc_q;
    assign mdc      = mdc_q;

    // half-period counter and mdc toggle; held low when not running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (at_top) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_build.sv
// Builds the full Clause 22 frame, MSB first, from the request fields.
// For a read, the turnaround and data positions hold ones (the line is released there).
module mdio_frame_build import mdio_pkg::*; #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32,
    parameter int FRAME_W = PRE_LEN + 4 + 2*ADDR_W + 2 + DATA_W
) (
    input  logic [OP_W-1:0]    op,
    input  logic [ADDR_W-1:0]  phy_addr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [FRAME_W-1:0] frame
);
    logic              is_rd;
    logic [1:0]        ta;
    logic [DATA_W-1:0] body;

    assign is_rd = (op == OP_READ);

    // choose the turnaround and data fields by direction
    always_comb begin
        ta   = is_rd ? TA_READ : TA_WRITE;
        body = is_rd ? {DATA_W{1'b1}} : wr_data;
    end

    assign frame = {{PRE_LEN{1'b1}}, START_SEQ, op, phy_addr, reg_addr, ta, body};
endmodule

// File: rtl/mdio_seq.sv
// Frame sequencer: accepts a request while idle, shifts the frame out on falling
// mdc strobes, releases the line for read turnaround and data, and samples the
// read data on rising strobes. A low enable abandons the frame.
// Assumes the strobes come from mdio_clkgen and never coincide.
module mdio_seq import mdio_pkg::*; #(
    parameter int DATA_W  = 16,
    parameter int FRAME_W = 64,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mdio_en,
    input  logic               run,
    input  logic               req,
    input  logic [OP_W-1:0]    op,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               ready,
    output logic               mdio_o,
    output logic               mdio_t,
    output logic [DATA_W-1:0]  rd_data
);
    localparam logic [CNT_W-1:0] BIT_END = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] BIT_RLS = CNT_W'(FRAME_W - DATA_W - 2);
    localparam logic [CNT_W-1:0] BIT_SMP = CNT_W'(FRAME_W - DATA_W + 1);

    mdio_state_t        state_q;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   bit_q;
    logic               is_rd_q;
    logic [DATA_W-1:0]  rdsh_q;
    logic [DATA_W-1:0]  rd_q;
    logic               o_q;
    logic               t_q;

    assign ready   = (state_q == ST_IDLE);
    assign mdio_o  = o_q;
    assign mdio_t  = t_q;
    assign rd_data = rd_q;

    // request acceptance, bit shifting, read sampling and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            bit_q   <= '0;
            is_rd_q <= 1'b0;
            rdsh_q  <= '0;
            rd_q    <= '0;
            o_q     <= 1'b1;
            t_q     <= 1'b1;
        end else if (!mdio_en) begin
            state_q <= ST_IDLE;
            o_q     <= 1'b1;
            t_q     <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req && run) begin
                        state_q <= ST_FRAME;
                        shift_q <= frame_in;
                        bit_q   <= '0;
                        is_rd_q <= (op == OP_READ);
                    end
                end
                ST_FRAME: begin
                    if (fall_stb) begin
                        if (bit_q == BIT_END) begin
                            state_q <= ST_IDLE;
                            o_q     <= 1'b1;
                            t_q     <= 1'b1;
                            if (is_rd_q) begin
                                rd_q <= rdsh_q;
                            end
                        end else begin
                            o_q     <= shift_q[FRAME_W-1];
                            shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
                            t_q     <= is_rd_q && (bit_q >= BIT_RLS);
                            bit_q   <= bit_q + 1'b1;
                        end
                    end else if (rise_stb && is_rd_q && (bit_q >= BIT_SMP)) begin
                        rdsh_q <= {rdsh_q[DATA_W-2:0], mdio_i};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO station-management master top: divides the host clock into mdc and runs
// one Clause 22 frame per accepted request. Single clock domain, synchronous
// active-low reset; mdio_i must already be synchronous to clk.
module mdio_master import mdio_pkg::*; #(
    parameter int DIV_W   = 5,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req,
    input  logic [OP_W-1:0]   op,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_t
);
    localparam int FRAME_W = PRE_LEN + 4 + 2*ADDR_W + 2 + DATA_W;

    logic               run;
    logic               rise_stb;
    logic               fall_stb;
    logic [FRAME_W-1:0] frame;

    // the bus runs only when enabled with a non-zero divide
    assign run = mdio_en && (clk_div != '0);

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div      (clk_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_build #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN),
        .FRAME_W (FRAME_W)
    ) u_build (
        .op       (op),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .frame    (frame)
    );

    mdio_seq #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdio_en  (mdio_en),
        .run      (run),
        .req      (req),
        .op       (op),
        .frame_in (frame),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .ready    (ready),
        .mdio_o   (mdio_o),
        .mdio_t   (mdio_t),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Port-level protocol checks for mdio_master, attached with bind.
module mdio_master_chk #(
    parameter int DIV_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdio_en,
    input logic [DIV_W-1:0] clk_div,
    input logic             req,
    input logic             ready,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_t
);
    // R2
    mdc_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mdio_en || clk_div == '0) |=> !mdc);

    // R3
    req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && mdio_en && clk_div != '0) |=> !ready);

    // R3
    req_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && (!mdio_en || clk_div == '0)) |=> ready);

    // R6
    out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!$stable(mdio_o) || !$stable(mdio_t)) && $past(mdio_en)) |-> $fell(mdc));

    // R8
    drive_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_t |-> !ready);
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdio_en (mdio_en),
    .clk_div (clk_div),
    .req     (req),
    .ready   (ready),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_t  (mdio_t)
);

// File: tb/mdio_master_bench.sv
// Bench for mdio_master: behavioural reference model compared on every clock,
// plus a PHY-side monitor and directed scenarios.
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_en = 1'b0;
    logic [4:0]  clk_div = 5'd0;
    logic        req = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [4:0]  phy_addr = 5'd0;
    logic [4:0]  reg_addr = 5'd0;
    logic [15:0] wr_data = 16'd0;
    logic        mdio_i = 1'b1;
    logic [15:0] rd_data;
    logic        ready, mdc, mdio_o, mdio_t;

    always #2 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .mdio_en(mdio_en), .clk_div(clk_div),
        .req(req), .op(op), .phy_addr(phy_addr), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .ready(ready), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_t(mdio_t)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // frame layout taken from R5 and R7
    function automatic logic [63:0] build_frame(input logic [1:0] o, input logic [4:0] p,
                                                input logic [4:0] r, input logic [15:0] d);
        if (o == 2'b10) return {32'hFFFF_FFFF, 2'b01, o, p, r, 2'b11, 16'hFFFF};
        return {32'hFFFF_FFFF, 2'b01, o, p, r, 2'b10, d};
    endfunction

    // ---------------- reference model ----------------
    int          m_cnt;
    bit          m_mdc, m_busy, m_rd_op, m_o, m_t;
    int          m_idx;
    bit [15:0]   m_sh, m_rd;
    bit          m_q[$];
    bit          m_run, m_top, m_fall, m_rise;
    logic [63:0] m_f;
    logic [15:0] phy_word = 16'h0000;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mdc = 0; m_busy = 0; m_rd_op = 0;
            m_o = 1; m_t = 1; m_idx = 0; m_sh = 0; m_rd = 0;
            m_q.delete();
        end else begin
            m_run  = mdio_en && (clk_div != 0);
            m_top  = (m_cnt >= int'(clk_div));
            m_fall = m_run && m_top && m_mdc;
            m_rise = m_run && m_top && !m_mdc;
            if (!mdio_en) begin
                m_busy = 0; m_o = 1; m_t = 1;
            end else if (m_busy) begin
                if (m_fall) begin
                    if (m_idx == 64) begin
                        m_busy = 0; m_o = 1; m_t = 1;
                        if (m_rd_op) m_rd = m_sh;
                    end else begin
                        m_o = m_q.pop_front();
                        m_t = m_rd_op && (m_idx >= 46);
                        m_idx++;
                    end
                end else if (m_rise && m_rd_op && m_idx >= 49) begin
                    m_sh = {m_sh[14:0], mdio_i};
                end
            end else if (req && m_run) begin
                m_busy = 1; m_idx = 0; m_rd_op = (op == 2'b10);
                m_f = build_frame(op, phy_addr, reg_addr, wr_data);
                m_q.delete();
                for (int i = 63; i >= 0; i--) m_q.push_back(m_f[i]);
            end
            if (!m_run) begin
                m_cnt = 0; m_mdc = 0;
            end else if (m_top) begin
                m_cnt = 0; m_mdc = !m_mdc;
            end else begin
                m_cnt++;
            end
        end
    end

    // PHY answers reads from phy_word, MSB first (R7)
    always @(negedge clk) begin
        if (m_busy && m_rd_op && m_idx >= 49 && m_idx <= 64) mdio_i = phy_word[64 - m_idx];
        else mdio_i = 1'b1;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(mdc === m_mdc, "R2", "mdc", mdc, m_mdc);
            chk(ready === !m_busy, "R3 R8", "ready", ready, !m_busy);
            chk(mdio_o === m_o, "R5", "mdio_o", mdio_o, m_o);
            chk(mdio_t === m_t, "R7", "mdio_t", mdio_t, m_t);
            chk(rd_data === m_rd, "R7", "rd_data", rd_data, m_rd);
        end
    end

    // R6: outputs move only where mdc falls (aborts excluded)
    logic p_o = 1'b1, p_t = 1'b1, p_mdc = 1'b0, p_en = 1'b0;
    always @(negedge clk) begin
        if (rst_n && p_en && mdio_en && (mdio_o !== p_o || mdio_t !== p_t))
            chk(p_mdc && !mdc, "R6", "output change without mdc fall", mdc, 0);
        p_o = mdio_o; p_t = mdio_t; p_mdc = mdc; p_en = mdio_en;
    end

    // PHY-side monitor: bits seen on rising mdc
    logic [63:0] mon_bits = '0;
    int mon_n = 0;
    int mon_rel = 0;
    always @(posedge mdc) begin
        if (rst_n) begin
            if (!mdio_t) begin
                mon_bits = {mon_bits[62:0], mdio_o};
                mon_n++;
            end else if (!ready && mon_n > 0) begin
                mon_rel++;
            end
        end
    end

    task automatic mon_clear();
        mon_bits = '0; mon_n = 0; mon_rel = 0;
    endtask

    task automatic issue(input logic [1:0] o, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d);
        @(negedge clk);
        op = o; phy_addr = p; reg_addr = r; wr_data = d; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic mdc_period(output int per);
        per = 0;
        while (mdc) @(negedge clk);
        while (!mdc) @(negedge clk);
        while (mdc) begin @(negedge clk); per++; end
        while (!mdc) begin @(negedge clk); per++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", "run did not end", 0, 1);
        finish_run();
    end

    initial begin
        int per;
        bit seen;
        logic [63:0] exp_f;
        logic [15:0] keep;

        repeat (5) @(negedge clk);
        // R1: values while reset is held
        chk(ready === 1'b1 && mdc === 1'b0 && mdio_t === 1'b1 && mdio_o === 1'b1,
            "R1", "idle outputs in reset", {ready, mdc, mdio_t, mdio_o}, 4'b1011);
        chk(rd_data === 16'h0, "R1", "rd_data in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: mdc period for two divide values
        mdio_en = 1'b1; clk_div = 5'd1;
        mdc_period(per);
        chk(per == 4, "R2", "mdc period div=1", per, 4);
        clk_div = 5'd3;
        mdc_period(per);
        chk(per == 8, "R2", "mdc period div=3", per, 8);

        // R5 R3: write frame content
        clk_div = 5'd1; mon_clear();
        issue(2'b01, 5'h13, 5'h0A, 16'hBEEF);
        chk(ready === 1'b0, "R3", "ready after accept", ready, 0);
        wait_ready();
        exp_f = build_frame(2'b01, 5'h13, 5'h0A, 16'hBEEF);
        chk(mon_n == 64, "R5", "write bits driven", mon_n, 64);
        chk(mon_bits === exp_f, "R5", "write frame", mon_bits, exp_f);

        // R7: read with released turnaround and data
        clk_div = 5'd2; phy_word = 16'hA5C3; mon_clear();
        issue(2'b10, 5'h01, 5'h1F, 16'h1234);
        wait_ready();
        exp_f = build_frame(2'b10, 5'h01, 5'h1F, 16'h0);
        chk(rd_data === 16'hA5C3, "R7", "read data", rd_data, 16'hA5C3);
        chk(mon_n == 46, "R7", "read bits driven", mon_n, 46);
        chk(mon_rel == 18, "R7", "read bits released", mon_rel, 18);
        chk(mon_bits[45:0] === exp_f[63:18], "R5", "read header", mon_bits[45:0], exp_f[63:18]);

        // R7: a write leaves rd_data alone
        mon_clear();
        issue(2'b01, 5'h02, 5'h03, 16'h0F0F);
        wait_ready();
        chk(rd_data === 16'hA5C3, "R7", "rd_data after write", rd_data, 16'hA5C3);

        // R4: request while busy is ignored
        clk_div = 5'd1; mon_clear();
        issue(2'b01, 5'h15, 5'h06, 16'h5A5A);
        repeat (20) @(negedge clk);
        issue(2'b10, 5'h0B, 5'h0C, 16'hFFFF);
        wait_ready();
        exp_f = build_frame(2'b01, 5'h15, 5'h06, 16'h5A5A);
        chk(mon_bits === exp_f, "R4", "first frame intact", mon_bits, exp_f);
        mon_clear();
        seen = 0;
        repeat (200) begin @(negedge clk); if (!ready) seen = 1; end
        chk(!seen && mon_n == 0, "R4", "no second frame", mon_n, 0);

        // R3 R2: requests dropped when disabled or divide zero
        mdio_en = 1'b0;
        issue(2'b01, 5'h01, 5'h01, 16'h1111);
        seen = 0;
        repeat (50) begin @(negedge clk); if (!ready || mdc) seen = 1; end
        chk(!seen, "R3", "request while disabled", seen, 0);
        mdio_en = 1'b1; clk_div = 5'd0;
        issue(2'b01, 5'h01, 5'h01, 16'h1111);
        seen = 0;
        repeat (50) begin @(negedge clk); if (!ready || mdc) seen = 1; end
        chk(!seen, "R2", "divide zero holds bus off", seen, 0);

        // R9: abort by dropping enable mid-read
        clk_div = 5'd2; phy_word = 16'h0001; keep = rd_data;
        issue(2'b10, 5'h04, 5'h05, 16'h0);
        repeat (300) @(negedge clk);
        chk(ready === 1'b0, "R9", "busy before abort", ready, 0);
        mdio_en = 1'b0;
        @(negedge clk);
        chk(ready === 1'b1 && mdio_t === 1'b1 && mdio_o === 1'b1, "R9", "released on abort",
            {ready, mdio_t, mdio_o}, 3'b111);
        chk(rd_data === keep, "R9", "rd_data kept", rd_data, keep);

        // R2 R5 R8: slowest divide, full write
        mdio_en = 1'b1; clk_div = 5'd31; mon_clear();
        issue(2'b01, 5'h1F, 5'h00, 16'h8001);
        wait_ready();
        exp_f = build_frame(2'b01, 5'h1F, 5'h00, 16'h8001);
        chk(mon_bits === exp_f, "R5", "write at div=31", mon_bits, exp_f);
        chk(mdio_t === 1'b1, "R8", "line released when done", mdio_t, 1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule